// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Pipeline

This block is the device-side model of an SDRAM's mode register and of the timing of its read data. It watches the command pins every clock. A load-mode command takes its settings from the 12-bit address bus: burst length, burst ordering, read latency, operating mode and write-burst policy. The block then reports the read burst length and the effective write burst length to the rest of the device model.

On every READ command it takes one word from the array side and returns it on the data outputs after the programmed latency of two or three clocks. The output-enable rises one clock before that word is valid. Consecutive READs produce data on consecutive cycles. No-operation and deselect cycles do not disturb reads that are still in flight.

A load-mode command with a reserved latency code or a non-standard operating mode is rejected as a whole. It also raises a sticky error flag.

Top module: `sdr_mode_rdpipe`

## Requirements
- R1: After reset, `cas_lat_o`=2, `rd_blen_o`=1, `wr_blen_o`=1, `interleave_o`=0, `mode_error_o`=0, `dq_vld_o`=0, `dq_oe_o`=0 and `dq_o`=0.
- R2: A load-mode command is `cs_ni`=0, `ras_ni`=0, `cas_ni`=0, `we_ni`=0. When it is accepted, address bits 6:4 set the latency: code 010 gives `cas_lat_o`=2 and code 011 gives `cas_lat_o`=3. The new values show after the clock edge that registers the command.
- R3: Address bits 2:0 set `rd_blen_o`: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives 256 (a full page) when bit 3 is 0. Code 111 with bit 3 set, and every other code, give 0. Bit 3 is shown on `interleave_o`.
- R4: Address bit 9 = 1 makes `wr_blen_o`=1. Address bit 9 = 0 makes `wr_blen_o` equal to `rd_blen_o`.
- R5: A load-mode command whose bits 6:4 are not 010 or 011, or whose bits 8:7 are not 00, changes no setting and sets `mode_error_o`. The flag stays high until reset. Bits 11:10 are not checked.
- R6: A READ is `cs_ni`=0, `ras_ni`=1, `cas_ni`=0, `we_ni`=1, and `arr_data_i` is captured with it. For a READ registered at edge n with latency m, `dq_vld_o` is high and `dq_o` carries the captured word for the one cycle after edge n+m. Otherwise `dq_o` is 0.
- R7: `dq_oe_o` is high from edge n+m-1 through the data cycle. It is high whenever `dq_vld_o` is high.
- R8: READs on consecutive cycles return their words on consecutive cycles, in order, with no gap.
- R9: Deselect (`cs_ni`=1, any other pins), NOP (`cs_ni`=0, others 1) and other commands leave every setting unchanged, and they do not disturb reads in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Address bus; carries the mode word on load |
| arr_data_i | input | DATA_W | Word from the array, captured with READ |
| dq_o | output | DATA_W | Read data out |
| dq_vld_o | output | 1 | Read data valid |
| dq_oe_o | output | 1 | Output driver enable |
| cas_lat_o | output | 2 | Current read latency in clocks |
| rd_blen_o | output | BLEN_W | Read burst length, 0 when reserved |
| wr_blen_o | output | BLEN_W | Effective write burst length |
| interleave_o | output | 1 | Burst ordering is interleaved |
| mode_error_o | output | 1 | Sticky rejected-load flag |

## Verification
Two functions can fall in the same cycle. A new READ can enter the pipeline while the previous word is leaving it. The enable lead of the later read can also overlap the data cycle of the earlier one. The bench provokes both by issuing two READs on consecutive cycles at latency 2, and by following a READ with deselect cycles at latency 3. Each is judged by sampling `dq_oe_o`, `dq_vld_o` and `dq_o` after every edge and comparing them with a window computed from the issue edge and the latency.

// File: rtl/sdr_mode_pkg.sv
package sdr_mode_pkg;
  localparam int MR_W     = 12;
  localparam int BL_LSB   = 0;
  localparam int BT_BIT   = 3;
  localparam int CL_LSB   = 4;
  localparam int OP_LSB   = 7;
  localparam int WB_BIT   = 9;

  localparam logic [2:0] CL_TWO   = 3'b010;
  localparam logic [2:0] CL_THREE = 3'b011;
  localparam logic [2:0] BL_PAGE  = 3'b111;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_LOAD,
    CMD_READ,
    CMD_OTHER
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mode_pkg::*;
(
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  output sdr_cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b000:  cmd_o = CMD_LOAD;
        3'b101:  cmd_o = CMD_READ;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_mode_pkg::*;
#(
  parameter int PAGE_COLS = 256,
  parameter int BLEN_W    = $clog2(PAGE_COLS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MR_W-1:0]   addr_i,
  output logic              cl3_o,
  output logic              interleave_o,
  output logic [BLEN_W-1:0] rd_blen_o,
  output logic [BLEN_W-1:0] wr_blen_o,
  output logic              mode_error_o
);
  logic [2:0] bl_q;
  logic       bt_q, cl3_q, wb_q, err_q;
  logic       fields_ok;

  assign fields_ok = (addr_i[CL_LSB +: 3] inside {CL_TWO, CL_THREE}) &&
                     (addr_i[OP_LSB +: 2] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q  <= '0;
      bt_q  <= 1'b0;
      cl3_q <= 1'b0;
      wb_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (load_i) begin
      if (fields_ok) begin
        bl_q  <= addr_i[BL_LSB +: 3];
        bt_q  <= addr_i[BT_BIT];
        cl3_q <= addr_i[CL_LSB];
        wb_q  <= addr_i[WB_BIT];
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  // reserved length codes report zero
  always_comb begin
    unique case (bl_q)
      3'd0:    rd_blen_o = BLEN_W'(1);
      3'd1:    rd_blen_o = BLEN_W'(2);
      3'd2:    rd_blen_o = BLEN_W'(4);
      3'd3:    rd_blen_o = BLEN_W'(8);
      BL_PAGE: rd_blen_o = bt_q ? '0 : BLEN_W'(PAGE_COLS);
      default: rd_blen_o = '0;
    endcase
  end

  assign wr_blen_o    = wb_q ? BLEN_W'(1) : rd_blen_o;
  assign cl3_o        = cl3_q;
  assign interleave_o = bt_q;
  assign mode_error_o = err_q;
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              vld_o,
  output logic              oe_o
);
  logic [MAX_LAT-1:0] vld_q;
  logic [DATA_W-1:0]  dat_q [MAX_LAT];
  logic               tap_vld;
  logic [DATA_W-1:0]  tap_dat;
  logic               out_vld_q;
  logic [DATA_W-1:0]  out_dat_q;

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else if (i == 0) begin
        vld_q[i] <= rd_i;
        dat_q[i] <= rd_i ? data_i : '0;
      end else begin
        vld_q[i] <= vld_q[(i == 0) ? 0 : i-1];
        dat_q[i] <= dat_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  // stage lat-1 holds the read one clock before its data cycle
  always_comb begin
    tap_vld = 1'b0;
    tap_dat = '0;
    for (int i = 0; i < MAX_LAT; i++) begin
      if (LAT_W'(i + 1) == lat_i) begin
        tap_vld = vld_q[i];
        tap_dat = dat_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_dat_q <= '0;
    end else begin
      out_vld_q <= tap_vld;
      out_dat_q <= tap_vld ? tap_dat : '0;
    end
  end

  assign dq_o  = out_dat_q;
  assign vld_o = out_vld_q;
  assign oe_o  = tap_vld | out_vld_q;
endmodule

// File: rtl/sdr_mode_rdpipe.sv
module sdr_mode_rdpipe
  import sdr_mode_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PAGE_COLS = 256,
  parameter int MAX_LAT   = 3,
  localparam int BLEN_W   = $clog2(PAGE_COLS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_vld_o,
  output logic              dq_oe_o,
  output logic [1:0]        cas_lat_o,
  output logic [BLEN_W-1:0] rd_blen_o,
  output logic [BLEN_W-1:0] wr_blen_o,
  output logic              interleave_o,
  output logic              mode_error_o
);
  localparam int LAT_W = $clog2(MAX_LAT + 1);

  sdr_cmd_e cmd;
  logic     cl3;

  sdr_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd)
  );

  sdr_mode_reg #(.PAGE_COLS(PAGE_COLS), .BLEN_W(BLEN_W)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (cmd == CMD_LOAD),
    .addr_i       (addr_i),
    .cl3_o        (cl3),
    .interleave_o (interleave_o),
    .rd_blen_o    (rd_blen_o),
    .wr_blen_o    (wr_blen_o),
    .mode_error_o (mode_error_o)
  );

  assign cas_lat_o = {1'b1, cl3};

  sdr_rd_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (cmd == CMD_READ),
    .data_i (arr_data_i),
    .lat_i  (LAT_W'(cas_lat_o)),
    .dq_o   (dq_o),
    .vld_o  (dq_vld_o),
    .oe_o   (dq_oe_o)
  );
endmodule

// File: rtl/sdr_mode_rdpipe_chk.sv
module sdr_mode_rdpipe_chk #(
  parameter int DATA_W = 16,
  parameter int BLEN_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              we_ni,
  input logic [11:0]       addr_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_vld_o,
  input logic              dq_oe_o,
  input logic [1:0]        cas_lat_o,
  input logic [BLEN_W-1:0] rd_blen_o,
  input logic [BLEN_W-1:0] wr_blen_o,
  input logic              interleave_o,
  input logic              mode_error_o
);
  logic is_load, is_read, word_ok;
  assign is_load = !cs_ni && !ras_ni && !cas_ni && !we_ni;
  assign is_read = !cs_ni && ras_ni && !cas_ni && we_ni;
  assign word_ok = (addr_i[6:4] == 3'b010 || addr_i[6:4] == 3'b011) && addr_i[8:7] == 2'b00;

  a_r2_latency_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load && word_ok |=> cas_lat_o == {1'b1, $past(addr_i[4])});

  a_r4_write_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load && word_ok && addr_i[9] |=> wr_blen_o == BLEN_W'(1));

  a_r5_rejected_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load && !word_ok |=> $stable(cas_lat_o) && $stable(rd_blen_o) &&
                            $stable(wr_blen_o) && mode_error_o);

  a_r5_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_error_o |=> mode_error_o);

  a_r6_cl2_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_read && cas_lat_o == 2'd2 |-> ##3 dq_vld_o);

  a_r6_cl3_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_read && cas_lat_o == 2'd3 |-> ##4 dq_vld_o);

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_vld_o |-> dq_o == '0);

  a_r7_oe_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_vld_o |-> dq_oe_o);

  a_r7_oe_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_vld_o) |-> $past(dq_oe_o));

  a_r9_settings_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_load |=> $stable(cas_lat_o) && $stable(rd_blen_o) && $stable(wr_blen_o) &&
                 $stable(interleave_o));
endmodule

bind sdr_mode_rdpipe sdr_mode_rdpipe_chk #(.DATA_W(DATA_W), .BLEN_W(BLEN_W)) u_chk (.*);

// File: tb/sdr_mode_rdpipe_tb.sv
module sdr_mode_rdpipe_tb;
  localparam int DW = 16;
  localparam int BW = 9;
  localparam int NV = 9;

  // load word, expected latency, read length, write length, interleave
  localparam logic [11:0] V_ADDR [NV] = '{12'h020, 12'h031, 12'h02A, 12'h033, 12'h037,
                                          12'h03F, 12'h232, 12'h025, 12'hC22};
  localparam int V_CL  [NV] = '{2, 3, 2, 3, 3, 3, 3, 2, 2};
  localparam int V_RBL [NV] = '{1, 2, 4, 8, 256, 0, 4, 0, 4};
  localparam int V_WBL [NV] = '{1, 2, 4, 8, 256, 0, 1, 0, 4};
  localparam int V_IL  [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [DW-1:0] adata = '0;
  logic [DW-1:0] dq;
  logic dq_vld, dq_oe, il, merr;
  logic [1:0] cl;
  logic [BW-1:0] rbl, wbl;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sdr_mode_rdpipe #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .addr_i(addr), .arr_data_i(adata), .dq_o(dq), .dq_vld_o(dq_vld),
    .dq_oe_o(dq_oe), .cas_lat_o(cl), .rd_blen_o(rbl), .wr_blen_o(wbl),
    .interleave_o(il), .mode_error_o(merr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pins(input logic c, r, a, w);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
  endtask

  task automatic load(input logic [11:0] word);
    @(negedge clk);
    pins(0, 0, 0, 0); addr = word;
    @(negedge clk);
    pins(0, 1, 1, 1); addr = '0;
  endtask

  task automatic chk_mode(input string tag, input int ecl, erbl, ewbl, eil, eerr);
    chk(int'(cl) == ecl, {tag, " latency"}, int'(cl), ecl);
    chk(int'(rbl) == erbl, {tag, " read length"}, int'(rbl), erbl);
    chk(int'(wbl) == ewbl, {tag, " write length"}, int'(wbl), ewbl);
    chk(int'(il) == eil, {tag, " interleave"}, int'(il), eil);
    chk(int'(merr) == eerr, {tag, " error"}, int'(merr), eerr);
  endtask

  // one read, then idle cycles (deselect when desel=1); sample after edges n..n+4
  task automatic one_read(input string tag, input int m, input logic [DW-1:0] d, input bit desel);
    @(negedge clk);
    pins(0, 1, 0, 1); adata = d;
    for (int k = 0; k <= 4; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (desel) pins(1, 0, 1, 0); else pins(0, 1, 1, 1);
        adata = ~d;
      end
      chk(dq_oe == (k == m-1 || k == m), {tag, " R7 enable"}, int'(dq_oe), int'(k == m-1 || k == m));
      chk(dq_vld == (k == m), {tag, " R6 valid"}, int'(dq_vld), int'(k == m));
      chk(dq == ((k == m) ? d : '0), {tag, " R6 data"}, int'(dq), (k == m) ? int'(d) : 0);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_mode("R1 reset", 2, 1, 1, 0, 0);
    chk(dq_vld == 0 && dq_oe == 0 && dq == '0, "R1 outputs idle", int'(dq_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pins(0, 1, 1, 1);

    // R2 R3 R4: table of load words
    for (int i = 0; i < NV; i++) begin
      load(V_ADDR[i]);
      chk_mode($sformatf("R2/R3/R4 vector %0d", i), V_CL[i], V_RBL[i], V_WBL[i], V_IL[i], 0);
    end

    // R9: deselect and a write command with a load-like address change nothing
    @(negedge clk); pins(1, 0, 0, 0); addr = 12'h033;
    @(negedge clk); pins(0, 1, 0, 0); addr = 12'h031;
    @(negedge clk); pins(0, 1, 1, 1); addr = '0;
    chk_mode("R9 non-load commands", 2, 4, 4, 0, 0);

    // R5: reserved latency, then reserved operating mode
    load(12'h042);
    chk_mode("R5 reserved latency", 2, 4, 4, 0, 1);
    load(12'h0B3);
    chk_mode("R5 reserved op mode", 2, 4, 4, 0, 1);
    load(12'h031);
    chk_mode("R5 sticky after good load", 3, 2, 2, 0, 1);

    // R6 R7: latency 3 with deselect cycles behind it
    one_read("CL3", 3, 16'hA5C3, 1'b1);
    load(12'h020);
    one_read("CL2", 2, 16'h1234, 1'b0);

    // R8: back-to-back reads at latency 2
    @(negedge clk); pins(0, 1, 0, 1); adata = 16'hBEEF;
    @(negedge clk); adata = 16'h0F0F;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) begin pins(0, 1, 1, 1); adata = '0; end
      chk(dq_oe == (k >= 1 && k <= 3), "R8 enable", int'(dq_oe), int'(k >= 1 && k <= 3));
      chk(dq_vld == (k == 2 || k == 3), "R8 valid", int'(dq_vld), int'(k == 2 || k == 3));
      chk(dq == ((k == 2) ? 16'hBEEF : (k == 3) ? 16'h0F0F : 16'h0), "R8 data", int'(dq),
          (k == 2) ? 16'hBEEF : (k == 3) ? 16'h0F0F : 0);
    end

    // R1: reset again clears settings and flag
    load(12'h23B);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_mode("R1 second reset", 2, 1, 1, 0, 0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule